// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Dispatcher

This block turns per-vector interrupt requests into memory-write messages. Each message is a 64-bit target address and a 32-bit data word. The data word is the configured 16-bit message data. Its low bits are replaced by the vector number, and how many low bits are replaced depends on how many vectors software has enabled. A request on a masked vector is not sent. It is kept in a pending word instead.

Software changes the configuration and then pulses a re-evaluate strobe. On that strobe the block drops pending bits that lie outside the enabled range. It then replays the pending vectors that are now unmasked, lowest vector first, one message for each accepted output cycle.

The output is a single registered message slot on a valid/ready handshake. While the slot is stalled, new requests are stored in the pending word. They go out by themselves once the slot drains. While the capability is enabled, the block also tells the legacy wired-interrupt logic to hold its request deasserted.

Top module: `msi_dispatch`

## Requirements
- R1: The message data is `{16'h0, D}`, where D is the configured 16-bit data with bits [k-1:0] replaced by the vector number. Here k is the effective log2 of the enabled count N = 2^k.
- R2: The message address is the configured 64-bit address with bits [1:0] forced to zero.
- R3: A legal request on a vector whose mask bit is 1 sends no message and sets that vector's bit in `pending_o` (bit i stands for vector i).
- R4: A legal unmasked request, made while the output slot is free and no replay is loading, produces `msg_valid_o` on the next clock edge.
- R5: A request with a vector number at or above N produces no message and sets no pending bit.
- R6: While `enable_i` is 0, requests and re-evaluate strobes have no effect: no message is produced and `pending_o` is unchanged.
- R7: `intx_deassert_o` is 1 exactly while `enable_i` is 1.
- R8: A re-evaluate strobe while enabled clears every pending bit at or above N.
- R9: After that strobe, each pending unmasked vector below N is sent in ascending vector order, one per accepted cycle, and its pending bit clears as it loads.
- R10: While `msg_valid_o` is 1 and `msg_ready_i` is 0, the address and data hold stable. A legal request in that time sets its pending bit, and once the slot frees it is sent without any strobe.
- R11: A `qsize_i` value above log2(VEC_N) is treated as log2(VEC_N).
- R12: With MASK_EN = 0, the mask input is ignored and `pending_o` stays zero.
- R13: Reset, asserted asynchronously, clears `pending_o` and `msg_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Capability enable |
| qsize_i | input | 3 | log2 of the enabled vector count |
| cfg_addr_i | input | 64 | Configured message address |
| cfg_data_i | input | 16 | Configured message data |
| mask_i | input | VEC_N | Per-vector mask, 1 = masked |
| reeval_i | input | 1 | Re-evaluate strobe after a configuration write |
| req_valid_i | input | 1 | Interrupt request strobe |
| req_vec_i | input | log2(VEC_N) | Requested vector number |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted when high with valid |
| msg_addr_o | output | 64 | Message address |
| msg_data_o | output | 32 | Message data |
| pending_o | output | VEC_N | Pending vectors |
| intx_deassert_o | output | 1 | Hold legacy interrupt deasserted |

## Verification
A direct request shows up on the message port one edge after it is sampled. A masked or stalled request shows up in `pending_o` after that same edge. A replay loads its first vector on the edge that samples the strobe, and each further vector on each following accepted edge. `intx_deassert_o` follows the enable with no delay, and reset clears state as soon as it is asserted. The bench drives every input just after a falling edge and samples just after the next falling edge, so each sample sees exactly one rising edge's effect. The sweep covers every `qsize_i` value against every vector number.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int ADDR_W     = 64;
  localparam int CFG_DATA_W = 16;
  localparam int MSG_DATA_W = 32;
  localparam int QSIZE_W    = 3;

  typedef struct packed {
    logic [ADDR_W-1:0]     addr;
    logic [MSG_DATA_W-1:0] data;
  } msi_msg_t;
endpackage

// File: rtl/msi_pick.sv
module msi_pick #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] hot_o,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end

  assign any_o = |req_i;
  assign hot_o = any_o ? (N'(1) << idx_o) : '0;
endmodule

// File: rtl/msi_fmt.sv
module msi_fmt import msi_pkg::*; #(
  parameter int VEC_W = 3
) (
  input  logic [QSIZE_W-1:0]    lg_i,
  input  logic [VEC_W-1:0]      vec_i,
  input  logic [CFG_DATA_W-1:0] cfg_i,
  output logic [MSG_DATA_W-1:0] data_o
);
  logic [CFG_DATA_W-1:0] low_m;

  assign low_m  = CFG_DATA_W'((32'd1 << lg_i) - 32'd1);
  assign data_o = {{(MSG_DATA_W-CFG_DATA_W){1'b0}},
                   (cfg_i & ~low_m) | (CFG_DATA_W'(vec_i) & low_m)};
endmodule

// File: rtl/msi_pend.sv
module msi_pend #(
  parameter int VEC_N   = 8,
  parameter bit MASK_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trim_i,
  input  logic [VEC_N-1:0] keep_i,
  input  logic [VEC_N-1:0] set_i,
  input  logic [VEC_N-1:0] clr_i,
  output logic [VEC_N-1:0] pend_o
);
  if (MASK_EN) begin : g_store
    logic [VEC_N-1:0] pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= '0;
      else         pend_q <= ((trim_i ? (pend_q & keep_i) : pend_q) & ~clr_i) | set_i;
    end
    assign pend_o = pend_q;
  end else begin : g_none
    logic unused_pend;
    assign unused_pend = ^{clk_i, rst_ni, trim_i, keep_i, set_i, clr_i};
    assign pend_o = '0;
  end
endmodule

// File: rtl/msi_dispatch.sv
module msi_dispatch import msi_pkg::*; #(
  parameter int VEC_N   = 8,
  parameter bit MASK_EN = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    enable_i,
  input  logic [QSIZE_W-1:0]      qsize_i,
  input  logic [ADDR_W-1:0]       cfg_addr_i,
  input  logic [CFG_DATA_W-1:0]   cfg_data_i,
  input  logic [VEC_N-1:0]        mask_i,
  input  logic                    reeval_i,
  input  logic                    req_valid_i,
  input  logic [$clog2(VEC_N)-1:0] req_vec_i,
  output logic                    msg_valid_o,
  input  logic                    msg_ready_i,
  output logic [ADDR_W-1:0]       msg_addr_o,
  output logic [MSG_DATA_W-1:0]   msg_data_o,
  output logic [VEC_N-1:0]        pending_o,
  output logic                    intx_deassert_o
);
  localparam int VEC_W = $clog2(VEC_N);

  logic [QSIZE_W-1:0] lg;
  logic [VEC_N-1:0]   range_m, mask_eff, pend, cand, pk_hot, req_hot;
  logic [VEC_N-1:0]   set_hot, clr_hot;
  logic [VEC_W-1:0]   pk_idx, ld_vec;
  logic               pk_any, slot_free, drain_q, drain_act, drain_ld;
  logic               req_ok, req_masked, direct_ld, deposit, dep_unm, ld;
  logic [MSG_DATA_W-1:0] ld_data;
  msi_msg_t           msg_q;
  logic               valid_q;

  // clamp oversized count request
  assign lg = (qsize_i > QSIZE_W'(VEC_W)) ? QSIZE_W'(VEC_W) : qsize_i;

  for (genvar g = 0; g < VEC_N; g++) begin : g_range
    assign range_m[g] = ((g >> lg) == 0);
  end

  if (MASK_EN) begin : g_mask
    assign mask_eff = mask_i;
  end else begin : g_nomask
    logic unused_mask;
    assign unused_mask = ^mask_i;
    assign mask_eff = '0;
  end

  logic unused_addr_lo;
  assign unused_addr_lo = ^cfg_addr_i[1:0];

  assign slot_free = !valid_q || msg_ready_i;
  assign cand      = pend & ~mask_eff & range_m & {VEC_N{enable_i}};
  assign drain_act = (drain_q | reeval_i) & enable_i;

  msi_pick #(.N(VEC_N)) u_pick (
    .req_i (cand),
    .hot_o (pk_hot),
    .idx_o (pk_idx),
    .any_o (pk_any)
  );

  assign drain_ld   = drain_act & pk_any & slot_free;
  assign req_hot    = VEC_N'(1) << req_vec_i;
  assign req_ok     = req_valid_i & enable_i & range_m[req_vec_i];
  assign req_masked = mask_eff[req_vec_i];
  assign direct_ld  = req_ok & ~req_masked & slot_free & ~drain_ld;
  assign deposit    = req_ok & ~direct_ld;
  assign dep_unm    = deposit & ~req_masked & MASK_EN;
  assign set_hot    = deposit ? req_hot : '0;
  assign clr_hot    = drain_ld ? pk_hot : '0;
  assign ld         = drain_ld | direct_ld;
  assign ld_vec     = drain_ld ? pk_idx : req_vec_i;

  msi_pend #(.VEC_N(VEC_N), .MASK_EN(MASK_EN)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trim_i (reeval_i & enable_i),
    .keep_i (range_m),
    .set_i  (set_hot),
    .clr_i  (clr_hot),
    .pend_o (pend)
  );

  msi_fmt #(.VEC_W(VEC_W)) u_fmt (
    .lg_i   (lg),
    .vec_i  (ld_vec),
    .cfg_i  (cfg_data_i),
    .data_o (ld_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drain_q <= 1'b0;
      valid_q <= 1'b0;
      msg_q   <= '0;
    end else begin
      drain_q <= enable_i & ((drain_act & |(cand & ~clr_hot)) | dep_unm);
      valid_q <= ld | (valid_q & ~msg_ready_i);
      if (ld) begin
        msg_q.addr <= {cfg_addr_i[ADDR_W-1:2], 2'b00};
        msg_q.data <= ld_data;
      end
    end
  end

  assign msg_valid_o     = valid_q;
  assign msg_addr_o      = msg_q.addr;
  assign msg_data_o      = msg_q.data;
  assign pending_o       = pend;
  assign intx_deassert_o = enable_i;
endmodule

// File: rtl/msi_dispatch_chk.sv
module msi_dispatch_chk import msi_pkg::*; #(
  parameter int VEC_N   = 8,
  parameter bit MASK_EN = 1'b1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     enable_i,
  input logic [QSIZE_W-1:0]       qsize_i,
  input logic [VEC_N-1:0]         mask_i,
  input logic                     reeval_i,
  input logic                     req_valid_i,
  input logic [$clog2(VEC_N)-1:0] req_vec_i,
  input logic                     msg_valid_o,
  input logic                     msg_ready_i,
  input logic [ADDR_W-1:0]        msg_addr_o,
  input logic [MSG_DATA_W-1:0]    msg_data_o,
  input logic [VEC_N-1:0]         pending_o
);
  localparam int VEC_W = $clog2(VEC_N);
  logic [5:0] nvec_c;
  logic       legal_c;

  assign nvec_c  = (qsize_i > QSIZE_W'(VEC_W)) ? 6'(VEC_N) : (6'd1 << qsize_i);
  assign legal_c = 32'(req_vec_i) < 32'(nvec_c);

  a_r10_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o));

  a_r1_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> msg_data_o[31:16] == 16'h0);

  a_r2_addr_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> msg_addr_o[1:0] == 2'b00);

  a_r8_trim_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reeval_i && enable_i |=> (32'(pending_o) >> $past(nvec_c)) == 32'd0);

  a_r6_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i && (!msg_valid_o || msg_ready_i) |=> !msg_valid_o);

  if (MASK_EN) begin : g_mask_chk
    a_r3_masked_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i && enable_i && legal_c && mask_i[req_vec_i] |=> pending_o[$past(req_vec_i)]);
  end
endmodule

bind msi_dispatch msi_dispatch_chk #(.VEC_N(VEC_N), .MASK_EN(MASK_EN)) u_chk (.*);

// File: tb/msi_dispatch_test.sv
module msi_dispatch_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, reeval = 1'b0, req_v = 1'b0, rdy = 1'b1;
  logic [2:0]  qsize = 3'd3, req_vec = 3'd0;
  logic [63:0] caddr = 64'h0000_00FE_E000_1237;
  logic [15:0] cdata = 16'hBEEF;
  logic [7:0]  mask = 8'h00;
  logic        vld, intx, nm_vld, nm_intx;
  logic [63:0] maddr, nm_addr;
  logic [31:0] mdata, nm_data;
  logic [7:0]  pend, nm_pend;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  msi_dispatch #(.VEC_N(8), .MASK_EN(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .qsize_i(qsize),
    .cfg_addr_i(caddr), .cfg_data_i(cdata), .mask_i(mask), .reeval_i(reeval),
    .req_valid_i(req_v), .req_vec_i(req_vec), .msg_valid_o(vld), .msg_ready_i(rdy),
    .msg_addr_o(maddr), .msg_data_o(mdata), .pending_o(pend), .intx_deassert_o(intx));

  msi_dispatch #(.VEC_N(8), .MASK_EN(1'b0)) uut_nm (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .qsize_i(qsize),
    .cfg_addr_i(caddr), .cfg_data_i(cdata), .mask_i(mask), .reeval_i(reeval),
    .req_valid_i(req_v), .req_vec_i(req_vec), .msg_valid_o(nm_vld), .msg_ready_i(rdy),
    .msg_addr_o(nm_addr), .msg_data_o(nm_data), .pending_o(nm_pend), .intx_deassert_o(nm_intx));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_data(input int q, input int v);
    int n = (q > 3) ? 8 : (1 << q);
    return {16'h0, (16'hBEEF & ~16'(n - 1)) | 16'(v)};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input int v);
    req_v = 1'b1;
    req_vec = 3'(v);
    tick();
    req_v = 1'b0;
  endtask

  initial begin
    #(CLK_P * 50000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R13 reset valid", 64'(vld), 64'd0);
    chk("R13 reset pending", 64'(pend), 64'd0);
    chk("R7 intx off", 64'(intx), 64'd0);
    en = 1'b1;
    #1;
    chk("R7 intx on", 64'(intx), 64'd1);

    // sweep every count against every vector (R1 R4 R5 R11)
    for (int q = 0; q < 8; q++) begin
      for (int v = 0; v < 8; v++) begin
        qsize = 3'(q);
        send(v);
        if (v < ((q > 3) ? 8 : (1 << q))) begin
          chk("R4 direct valid", 64'(vld), 64'd1);
          chk(q > 3 ? "R11 clamp data" : "R1 data merge", 64'(mdata), 64'(exp_data(q, v)));
        end else begin
          chk("R5 illegal no msg", 64'(vld), 64'd0);
          chk("R5 illegal no pend", 64'(pend), 64'd0);
        end
      end
    end
    chk("R2 address", maddr, 64'h0000_00FE_E000_1234);
    tick();

    // masked requests then replay
    qsize = 3'd3;
    mask = 8'hA5;
    for (int v = 0; v < 8; v++) begin
      send(v);
      if (mask[v]) begin
        chk("R3 masked no msg", 64'(vld), 64'd0);
        chk("R12 mask ignored", 64'(nm_vld), 64'd1);
      end else begin
        chk("R4 unmasked msg", 64'(mdata), 64'(exp_data(3, v)));
      end
      chk("R12 pend zero", 64'(nm_pend), 64'd0);
    end
    chk("R3 pending word", 64'(pend), 64'hA5);
    mask = 8'h00;
    qsize = 3'd2;
    reeval = 1'b1;
    tick();
    reeval = 1'b0;
    chk("R9 replay first", 64'(mdata), 64'(exp_data(2, 0)));
    chk("R8 trimmed pending", 64'(pend), 64'h04);
    tick();
    chk("R9 replay second", 64'(mdata), 64'(exp_data(2, 2)));
    chk("R9 pending empty", 64'(pend), 64'h00);
    tick();
    chk("R9 replay done", 64'(vld), 64'd0);

    // stall behaviour
    qsize = 3'd3;
    rdy = 1'b0;
    send(1);
    chk("R10 first msg", 64'(mdata), 64'(exp_data(3, 1)));
    send(6);
    chk("R10 held data", 64'(mdata), 64'(exp_data(3, 1)));
    chk("R10 stalled pend", 64'(pend), 64'h40);
    send(3);
    chk("R10 stalled pend2", 64'(pend), 64'h48);
    rdy = 1'b1;
    tick();
    chk("R10 auto send low", 64'(mdata), 64'(exp_data(3, 3)));
    chk("R10 pend after", 64'(pend), 64'h40);
    tick();
    chk("R10 auto send high", 64'(mdata), 64'(exp_data(3, 6)));
    chk("R10 pend clear", 64'(pend), 64'h00);
    tick();
    chk("R10 idle", 64'(vld), 64'd0);

    // disabled
    mask = 8'h10;
    send(4);
    chk("R3 pend vec4", 64'(pend), 64'h10);
    en = 1'b0;
    #1;
    chk("R7 intx follows", 64'(intx), 64'd0);
    send(2);
    chk("R6 disabled no msg", 64'(vld), 64'd0);
    chk("R6 disabled pend", 64'(pend), 64'h10);
    mask = 8'h00;
    reeval = 1'b1;
    tick();
    reeval = 1'b0;
    chk("R6 reeval ignored", 64'(vld), 64'd0);
    chk("R6 pend kept", 64'(pend), 64'h10);
    en = 1'b1;
    reeval = 1'b1;
    tick();
    reeval = 1'b0;
    chk("R9 replay vec4", 64'(mdata), 64'(exp_data(3, 4)));
    chk("R9 pend vec4 clear", 64'(pend), 64'h00);
    tick();

    // reset mid-run
    rdy = 1'b0;
    mask = 8'h01;
    send(2);
    send(0);
    chk("R3 pend before rst", 64'(pend), 64'h01);
    rst_n = 1'b0;
    #1;
    chk("R13 async valid", 64'(vld), 64'd0);
    chk("R13 async pend", 64'(pend), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule